// File: doc/BRIEF.md
# Coherence Transition Checker

This block runs beside one cache controller and checks that controller at runtime. It keeps its own copy of the stable MSI state of every line. The controller's tags are never used for this. Whenever a line's stable state changes, the controller hands over a completed-transition record. The record holds the line index, the state before, the state after, the triggering event and the action taken. The checker replays the event through a reduced MSI protocol and compares the result with what the controller reported. It then emits a one-cycle result pulse that carries a diagnosis code.

When a transition checks clean, three things happen at the same clock edge: the private tag for the line takes the new state; if the transition must be announced to other nodes, a validation message goes into a small send buffer; and the result pulse is registered. The validation bus drains the send buffer. When the buffer is full, the record input is held off.

A watchdog watches the buffer head. If it stays refused for too long, the watchdog raises an omission alarm, which points to a deadlocked or livelocked system.

The control is a two-state machine, described below.
- CK_IDLE: waits for a record.
- CK_EVAL: evaluates the captured record.
- CK_IDLE to CK_EVAL: taken when a record is accepted.
- CK_EVAL to CK_IDLE: taken unconditionally after one cycle.

Top module: `coh_txn_checker`

## Requirements
- R1: After reset every private tag holds I, `rec_ready` is 1, and `chk_done`, `val_valid` and `wd_fire` are 0.
- R2: A record is taken at a clock edge where `rec_valid` and `rec_ready` are both 1. At the next edge `chk_done` pulses for one cycle with `chk_code`. `rec_ready` is 0 during that evaluation cycle.
- R3: If the reported initial state differs from the private tag of the line, `chk_code` is 1. State encodings are I=0, S=1, M=2.
- R4: Otherwise, if the reported final state differs from the reference next state, `chk_code` is 2.
- R5: Otherwise, if the reported action differs from the reference action, `chk_code` is 3. If every field agrees, `chk_code` is 0.
- R6: The reference protocol uses events LOAD=0, STORE=1, SNOOP_READ=2, SNOOP_READX=3, EVICT=4 and actions NONE=0, GET_SHARED=1, GET_EXCL=2, UPGRADE=3, SUPPLY=4, WRITEBACK=5. Its transitions are:
  - I+LOAD goes to S with GET_SHARED.
  - I+STORE goes to M with GET_EXCL.
  - S+STORE goes to M with UPGRADE.
  - S+SNOOP_READX and S+EVICT go to I with NONE.
  - M+SNOOP_READ goes to S with SUPPLY.
  - M+SNOOP_READX goes to I with SUPPLY.
  - M+EVICT goes to I with WRITEBACK.
  - Every other pair keeps the state with NONE.
- R7: A record with code 0 writes its final state into the line's private tag. A record with a nonzero code leaves the tag unchanged.
- R8: A code-0 record whose change is I→S, I→M, S→M or M→I enqueues one message (`val_addr` = line, `val_state` = final state). M→S, S→I, unchanged lines and failed records enqueue nothing.
- R9: Messages leave in enqueue order. `val_valid`, `val_addr` and `val_state` hold steady until `val_ready` is 1.
- R10: `rec_ready` is 0 while the send buffer holds SBUF_DEPTH messages.
- R11: `wd_fire` pulses for one cycle after WD_LIMIT consecutive cycles with `val_valid`=1 and `val_ready`=0. The count then restarts, and it clears whenever the head is not stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Transition record present |
| rec_ready | output | 1 | Checker can take a record |
| rec_addr | input | IDX_W | Line index of the record |
| rec_init | input | 2 | Reported state before the transition |
| rec_final | input | 2 | Reported state after the transition |
| rec_event | input | 3 | Event that caused the transition |
| rec_action | input | 3 | Action the controller performed |
| chk_done | output | 1 | One-cycle result pulse |
| chk_code | output | 2 | Diagnosis: 0 ok, 1 initial, 2 final, 3 action |
| val_valid | output | 1 | Validation message at buffer head |
| val_ready | input | 1 | Validation bus takes the head message |
| val_addr | output | IDX_W | Line index of the head message |
| val_state | output | 2 | New state announced by the head message |
| wd_fire | output | 1 | Omission alarm pulse |

## Verification
The embedded properties are checked on every cycle:
- the send buffer never overflows;
- each result pulse follows an acceptance exactly two edges earlier;
- only clean transitions reach the buffer;
- a refused head message holds steady;
- the alarm is a single pulse that follows a stall;
- no private tag ever holds the unused encoding.

Only the bench's scenarios can show the rest. These behaviours are:
- the protocol table itself;
- the priority among the three mismatch codes;
- the fact that a failed record leaves the tag untouched, which the bench sees through the code returned by the next record;
- which state changes produce broadcasts;
- FIFO ordering after a long stall.

// File: rtl/coh_chk_pkg.sv
package coh_chk_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_st_e;

    typedef enum logic [2:0] {
        EV_LOAD   = 3'd0,
        EV_STORE  = 3'd1,
        EV_SNP_RD = 3'd2,
        EV_SNP_RX = 3'd3,
        EV_EVICT  = 3'd4
    } event_e;

    typedef enum logic [2:0] {
        AC_NONE   = 3'd0,
        AC_GET_SH = 3'd1,
        AC_GET_EX = 3'd2,
        AC_UPGR   = 3'd3,
        AC_SUPPLY = 3'd4,
        AC_WBACK  = 3'd5
    } action_e;

    typedef enum logic [1:0] {
        DG_OK    = 2'd0,
        DG_INIT  = 2'd1,
        DG_FINAL = 2'd2,
        DG_ACT   = 2'd3
    } diag_e;

    typedef enum logic {
        CK_IDLE = 1'b0,
        CK_EVAL = 1'b1
    } ck_fsm_e;

endpackage

// File: rtl/coh_ref_protocol.sv
module coh_ref_protocol
    import coh_chk_pkg::*;
(
    input  logic [1:0] cur_st,
    input  logic [2:0] ev,
    output logic [1:0] nxt_st,
    output logic [2:0] act
);
    line_st_e cur;
    event_e   e;
    line_st_e n;
    action_e  a;

    assign cur = line_st_e'(cur_st);
    assign e   = event_e'(ev);

    // Reduced MSI protocol (R6)
    always_comb begin
        n = cur;
        a = AC_NONE;
        unique case (cur)
            ST_I: begin
                if (e == EV_LOAD) begin
                    n = ST_S; a = AC_GET_SH;
                end else if (e == EV_STORE) begin
                    n = ST_M; a = AC_GET_EX;
                end
            end
            ST_S: begin
                if (e == EV_STORE) begin
                    n = ST_M; a = AC_UPGR;
                end else if (e == EV_SNP_RX || e == EV_EVICT) begin
                    n = ST_I; a = AC_NONE;
                end
            end
            ST_M: begin
                if (e == EV_SNP_RD) begin
                    n = ST_S; a = AC_SUPPLY;
                end else if (e == EV_SNP_RX) begin
                    n = ST_I; a = AC_SUPPLY;
                end else if (e == EV_EVICT) begin
                    n = ST_I; a = AC_WBACK;
                end
            end
            default: begin
                n = cur;
                a = AC_NONE;
            end
        endcase
    end

    assign nxt_st = n;
    assign act    = a;
endmodule

// File: rtl/coh_arch_tags.sv
module coh_arch_tags
    import coh_chk_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_st,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_st
);
    localparam int LINES = 1 << IDX_W;

    logic [1:0] tag_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                tag_q[g] <= ST_I;
            else if (wr_en && wr_idx == IDX_W'(g))
                tag_q[g] <= wr_st;
        end

        // R7: only legal MSI encodings are ever stored
        p_tag_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
            tag_q[g] != 2'd3);
    end

    assign rd_st = tag_q[rd_idx];
endmodule

// File: rtl/coh_send_fifo.sv
module coh_send_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         nonempty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_pop;

    assign do_pop   = pop && nonempty;
    assign nonempty = (count != '0);
    assign full     = (count == CNT_W'(DEPTH));
    assign dout     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (push && !do_pop)
                count <= count + 1'b1;
            else if (!push && do_pop)
                count <= count - 1'b1;
        end
    end

    // R10: never write into a full buffer
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || do_pop));
endmodule

// File: rtl/coh_omission_wd.sv
module coh_omission_wd #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall,
    output logic fire
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else if (!stall) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else if (cnt == CNT_W'(LIMIT - 1)) begin
            cnt  <= '0;
            fire <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            fire <= 1'b0;
        end
    end

    // R11: alarm is a single pulse and follows a stalled cycle
    p_wd_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    p_wd_after_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fire) |-> $past(stall));
endmodule

// File: rtl/coh_txn_checker.sv
module coh_txn_checker
    import coh_chk_pkg::*;
#(
    parameter int IDX_W      = 4,
    parameter int SBUF_DEPTH = 4,
    parameter int WD_LIMIT   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_valid,
    output logic             rec_ready,
    input  logic [IDX_W-1:0] rec_addr,
    input  logic [1:0]       rec_init,
    input  logic [1:0]       rec_final,
    input  logic [2:0]       rec_event,
    input  logic [2:0]       rec_action,
    output logic             chk_done,
    output logic [1:0]       chk_code,
    output logic             val_valid,
    input  logic             val_ready,
    output logic [IDX_W-1:0] val_addr,
    output logic [1:0]       val_state,
    output logic             wd_fire
);
    localparam int MSG_W = IDX_W + 2;

    ck_fsm_e          state_q, state_d;
    logic [IDX_W-1:0] cap_addr;
    logic [1:0]       cap_init, cap_final;
    logic [2:0]       cap_event, cap_action;

    logic [1:0]       arch_st, ref_nxt;
    logic [2:0]       ref_act;
    diag_e            code_d;
    logic             eval, clean, announce, push;
    logic             sbuf_full;
    logic [MSG_W-1:0] sbuf_out;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CK_IDLE;
        else        state_q <= state_d;
    end

    // Next state and combinational outputs
    always_comb begin
        state_d   = state_q;
        rec_ready = 1'b0;
        eval      = 1'b0;
        unique case (state_q)
            CK_IDLE: begin
                rec_ready = !sbuf_full;
                if (rec_valid && !sbuf_full) state_d = CK_EVAL;
            end
            CK_EVAL: begin
                eval    = 1'b1;
                state_d = CK_IDLE;
            end
            default: state_d = CK_IDLE;
        endcase
    end

    // Record capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr   <= '0;
            cap_init   <= '0;
            cap_final  <= '0;
            cap_event  <= '0;
            cap_action <= '0;
        end else if (rec_valid && rec_ready) begin
            cap_addr   <= rec_addr;
            cap_init   <= rec_init;
            cap_final  <= rec_final;
            cap_event  <= rec_event;
            cap_action <= rec_action;
        end
    end

    coh_arch_tags #(.IDX_W(IDX_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (cap_addr),
        .rd_st  (arch_st),
        .wr_en  (eval && clean),
        .wr_idx (cap_addr),
        .wr_st  (cap_final)
    );

    coh_ref_protocol u_ref (
        .cur_st (arch_st),
        .ev     (cap_event),
        .nxt_st (ref_nxt),
        .act    (ref_act)
    );

    // Diagnosis with fixed priority: initial, final, action
    always_comb begin
        if (cap_init != arch_st)        code_d = DG_INIT;
        else if (cap_final != ref_nxt)  code_d = DG_FINAL;
        else if (cap_action != ref_act) code_d = DG_ACT;
        else                            code_d = DG_OK;
    end

    assign clean = (code_d == DG_OK);

    always_comb begin
        unique case (line_st_e'(arch_st))
            ST_I:    announce = (cap_final == ST_S) || (cap_final == ST_M);
            ST_S:    announce = (cap_final == ST_M);
            ST_M:    announce = (cap_final == ST_I);
            default: announce = 1'b0;
        endcase
    end

    assign push = eval && clean && announce;

    // Result pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_done <= 1'b0;
            chk_code <= DG_OK;
        end else begin
            chk_done <= eval;
            if (eval) chk_code <= code_d;
        end
    end

    coh_send_fifo #(.DEPTH(SBUF_DEPTH), .W(MSG_W)) u_sbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .din      ({cap_addr, cap_final}),
        .pop      (val_ready),
        .dout     (sbuf_out),
        .nonempty (val_valid),
        .full     (sbuf_full)
    );

    assign val_addr  = sbuf_out[MSG_W-1:2];
    assign val_state = sbuf_out[1:0];

    coh_omission_wd #(.LIMIT(WD_LIMIT)) u_wd (
        .clk   (clk),
        .rst_n (rst_n),
        .stall (val_valid && !val_ready),
        .fire  (wd_fire)
    );

    // R2: each result pulse follows an acceptance two edges before
    p_done_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> $past(rec_valid && rec_ready, 2));
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_ready) |=> !rec_ready);
    // R8: only clean transitions reach the send buffer
    p_bcast_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (chk_done && chk_code == DG_OK));
    // R9: a refused head message holds steady
    p_head_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (val_valid && !val_ready) |=> (val_valid && $stable(val_addr) && $stable(val_state)));
endmodule

// File: tb/coh_txn_checker_tb_top.sv
module coh_txn_checker_tb_top;
    localparam int IDX_W = 4;
    localparam int DEPTH = 4;
    localparam int WDL   = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rec_valid = 1'b0;
    logic             rec_ready;
    logic [IDX_W-1:0] rec_addr = '0;
    logic [1:0]       rec_init = '0, rec_final = '0;
    logic [2:0]       rec_event = '0, rec_action = '0;
    logic             chk_done;
    logic [1:0]       chk_code;
    logic             val_valid;
    logic             val_ready = 1'b1;
    logic [IDX_W-1:0] val_addr;
    logic [1:0]       val_state;
    logic             wd_fire;

    int n_chk = 0;
    int n_err = 0;
    bit run_cmp = 1'b0;

    always #10 clk = ~clk;

    coh_txn_checker #(.IDX_W(IDX_W), .SBUF_DEPTH(DEPTH), .WD_LIMIT(WDL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_addr(rec_addr),
        .rec_init(rec_init), .rec_final(rec_final), .rec_event(rec_event),
        .rec_action(rec_action), .chk_done(chk_done), .chk_code(chk_code),
        .val_valid(val_valid), .val_ready(val_ready), .val_addr(val_addr),
        .val_state(val_state), .wd_fire(wd_fire)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_tag [16];
    int m_q [$];
    bit m_eval, m_done, m_fire;
    int m_code, m_wd;
    int c_addr, c_init, c_fin, c_ev, c_act;

    // Protocol table written as a list of allowed triples
    function automatic void ref_step(input int st, input int ev, output int ns, output int ac);
        ns = st; ac = 0;
        if (st == 0 && ev == 0) begin ns = 1; ac = 1; end
        if (st == 0 && ev == 1) begin ns = 2; ac = 2; end
        if (st == 1 && ev == 1) begin ns = 2; ac = 3; end
        if (st == 1 && (ev == 3 || ev == 4)) begin ns = 0; ac = 0; end
        if (st == 2 && ev == 2) begin ns = 1; ac = 4; end
        if (st == 2 && ev == 3) begin ns = 0; ac = 4; end
        if (st == 2 && ev == 4) begin ns = 0; ac = 5; end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_tag[i] = 0;
            m_q.delete();
            m_eval = 0; m_done = 0; m_fire = 0; m_code = 0; m_wd = 0;
        end else begin
            bit stall_pre, ready_pre;
            int arch, rn, ra;
            stall_pre = (m_q.size() > 0) && !val_ready;
            ready_pre = !m_eval && (m_q.size() < DEPTH);
            if (m_q.size() > 0 && val_ready) void'(m_q.pop_front());
            m_done = 0;
            if (m_eval) begin
                arch = m_tag[c_addr];
                ref_step(arch, c_ev, rn, ra);
                if (c_init != arch)     m_code = 1;
                else if (c_fin != rn)   m_code = 2;
                else if (c_act != ra)   m_code = 3;
                else                    m_code = 0;
                if (m_code == 0) begin
                    if ((arch == 0 && c_fin == 1) || (arch == 0 && c_fin == 2) ||
                        (arch == 1 && c_fin == 2) || (arch == 2 && c_fin == 0))
                        m_q.push_back(c_addr * 4 + c_fin);
                    m_tag[c_addr] = c_fin;
                end
                m_done = 1;
                m_eval = 0;
            end else if (rec_valid && ready_pre) begin
                c_addr = int'(rec_addr); c_init = int'(rec_init); c_fin = int'(rec_final);
                c_ev = int'(rec_event); c_act = int'(rec_action);
                m_eval = 1;
            end
            if (stall_pre) begin
                if (m_wd == WDL - 1) begin m_fire = 1; m_wd = 0; end
                else begin m_fire = 0; m_wd++; end
            end else begin
                m_fire = 0; m_wd = 0;
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (run_cmp) begin
            check("R10 rec_ready", int'(rec_ready), int'(!m_eval && m_q.size() < DEPTH));
            check("R2 chk_done", int'(chk_done), int'(m_done));
            if (m_done) begin
                if (m_code == 1)      check("R3 chk_code", int'(chk_code), m_code);
                else if (m_code == 2) check("R4 chk_code", int'(chk_code), m_code);
                else if (m_code == 3) check("R5 chk_code", int'(chk_code), m_code);
                else                  check("R6/R7 chk_code", int'(chk_code), m_code);
            end
            check("R9 val_valid", int'(val_valid), int'(m_q.size() > 0));
            if (m_q.size() > 0) begin
                check("R8 val_addr", int'(val_addr), m_q[0] / 4);
                check("R8 val_state", int'(val_state), m_q[0] % 4);
            end
            check("R11 wd_fire", int'(wd_fire), int'(m_fire));
        end
    end

    task automatic send(input int a, input int i, input int f, input int e, input int ac);
        rec_addr = IDX_W'(a); rec_init = 2'(i); rec_final = 2'(f);
        rec_event = 3'(e); rec_action = 3'(ac);
        rec_valid = 1'b1;
        forever begin
            if (rec_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
        rec_valid = 1'b0;
        @(negedge clk);
    endtask

    // Encodings: I=0 S=1 M=2; LOAD=0 STORE=1 SNP_RD=2 SNP_RX=3 EVICT=4;
    // NONE=0 GET_SH=1 GET_EX=2 UPGR=3 SUPPLY=4 WBACK=5
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rec_ready", int'(rec_ready), 1);
        check("R1 chk_done", int'(chk_done), 0);
        check("R1 val_valid", int'(val_valid), 0);
        check("R1 wd_fire", int'(wd_fire), 0);
        run_cmp = 1'b1;

        send(1, 0, 1, 0, 1);   // R6 R8: I->S load, broadcast
        send(1, 1, 2, 1, 3);   // R8: S->M upgrade, broadcast
        send(1, 2, 1, 2, 4);   // R8: M->S snoop read, no broadcast
        send(1, 2, 0, 3, 4);   // R3: tag is S, record claims M
        send(1, 1, 0, 3, 0);   // R7: tag stayed S, S->I accepted silently
        send(2, 0, 2, 1, 2);   // I->M store
        send(2, 2, 0, 4, 5);   // R8: M->I writeback, broadcast
        send(3, 0, 2, 0, 1);   // R4: load cannot reach M
        send(3, 0, 1, 0, 5);   // R5: wrong action; tag still I (R7)
        send(3, 0, 0, 2, 0);   // R6: unchanged line, no broadcast
        send(5, 1, 1, 0, 0);   // R3: line 5 still I after reset (R1)

        // R10/R11/R9: stall the bus, fill the buffer, fire the watchdog
        val_ready = 1'b0;
        for (int k = 0; k < DEPTH; k++) send(6 + k, 0, 1, 0, 1);
        repeat (40) @(negedge clk);
        val_ready = 1'b1;
        send(12, 0, 2, 1, 2);  // waited on back-pressure, then accepted
        send(12, 2, 0, 3, 4);  // M->I by snoop readx, broadcast
        repeat (20) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog run hung actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule